// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block is a slave serial audio port. An external master drives the bit clock and the word select line. The port turns the incoming serial stream into parallel left and right 20-bit words. At the same time it sends two parallel 20-bit words back out on its serial output. The bit clock and word select are treated as data and sampled by the chip's system clock. The system clock must run at least eight times faster than the bit clock. There may be at most 64 bit clock cycles per stereo frame.

A 3-bit format input picks the framing at run time:

| Code | Receive framing | Transmit framing |
|------|-----------------|------------------|
| 0 | I2S | I2S |
| 1 | MSB-justified | MSB-justified |
| 2, 3, 4 | LSB-justified, 16, 18 or 20 bits | LSB-justified, same width |
| 5, 6, 7 | LSB-justified, 16, 18 or 20 bits | MSB-justified, full 20 bits |

Every bit period is a slot, numbered from slot 0. Slot 0 is the first bit clock period after a word select transition. Parallel words are always MSB-aligned, so the top bit of the 20-bit register is the first serial bit. Shorter words fill only the upper bits, and the lower bits read as zero.

Top module: `serial_audio_port`

## Requirements
- R1: While reset is asserted and until the first completed word, rxLeft and rxRight read zero, and rxValid and sdo are low.
- R2: In code 0, word select low marks the left channel. In all other codes, word select high marks the left channel.
- R3: In code 0, receive takes the word MSB first from slots 1 to 20 of each channel half. Slot 0 and slots after 20 are ignored.
- R4: In code 1, receive takes the word MSB first from slots 0 to 19. When a half has fewer than 20 slots, the missing low bits read zero. Bits in slots after 19 are ignored.
- R5: In codes 2 to 7, receive takes the last N slots before the next word select transition (N = 16, 18 or 20 by code). The word is placed MSB-aligned with the low 20-N bits zero, and earlier slots are ignored.
- R6: After each word select transition, rxValid pulses for exactly one cycle. rxIsLeft names the channel that just ended, and that channel's output register takes the new word. The first transition after reset produces no pulse.
- R7: In transmit codes 0, 1 and 5 to 7, sdo carries the selected channel's word MSB first. It uses slots 1 to 20 for code 0 and slots 0 to 19 otherwise, and is low in all other slots.
- R8: In codes 2 to 4, sdo carries the top N bits of the word, MSB first, in the last N slots of the half. The half length is taken as the length of the preceding half. sdo is low in all other slots.
- R9: Codes 5 to 7 receive as in R5 and transmit as in R7 with offset 0.
- R10: sdi is sampled on the rising bit clock edge. The slot index advances only on falling edges and restarts at each word select transition. sdo settles within 4 system clock cycles of a falling bit clock edge or a word select transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmt | input | 3 | Framing code (see R2) |
| bck | input | 1 | Serial bit clock from the master |
| ws | input | 1 | Word select from the master |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| txLeft | input | 20 | Left word to transmit |
| txRight | input | 20 | Right word to transmit |
| rxLeft | output | 20 | Last received left word |
| rxRight | output | 20 | Last received right word |
| rxValid | output | 1 | One-cycle pulse when a word is latched |
| rxIsLeft | output | 1 | Channel of the word latched with rxValid |

## Verification
The assertions check the following on every cycle:
- a word select transition restarts the slot index;
- the slot index holds between falling edges;
- rxValid never lasts two cycles;
- 16-bit words arrive with clear low bits;
- sdo stays low outside the transmit window in the MSB-justified and I2S framings.

Only the bench scenarios can show the rest:
- that bit order, slot offsets and channel polarity are right for each code;
- that junk bits outside the window are ignored;
- that short halves pad with zeros;
- that LSB-justified transmit lines up with the half length measured on the preceding half.

// File: rtl/sai_pkg.sv
package sai_pkg;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_MSB   = 3'd1,
    FMT_LSB16 = 3'd2,
    FMT_LSB18 = 3'd3,
    FMT_LSB20 = 3'd4,
    FMT_MIX16 = 3'd5,
    FMT_MIX18 = 3'd6,
    FMT_MIX20 = 3'd7
  } fmtSel_e;

  // Strobes handed from control to datapath, one system clock wide.
  typedef struct packed {
    logic sampleRise;  // rising bit clock seen, sdiBit is valid
    logic wsEdge;      // word select changed
    logic latchEn;     // completed word may be published
    logic endLeft;     // the half that just ended was the left channel
    logic curLeft;     // the half now running is the left channel
    logic sdiBit;      // synchronised serial input
  } ctrlStrobe_t;

  function automatic int lsbWidth(fmtSel_e f);
    case (f)
      FMT_LSB16, FMT_MIX16: return 16;
      FMT_LSB18, FMT_MIX18: return 18;
      default:              return 20;
    endcase
  endfunction

endpackage

// File: rtl/sai_ctrl.sv
module sai_ctrl
  import sai_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtSel_e           fmt,
  input  logic              bck,
  input  logic              ws,
  input  logic              sdi,
  output ctrlStrobe_t       stb,
  output logic [POS_W-1:0]  pos,
  output logic [POS_W:0]    halfLen
);

  logic s1Bck, s2Bck, s1Ws, wsPrev, s1Sdi, armed;
  logic fall, rise, wsEdge, isI2s;

  always_comb begin
    fall   = s2Bck & ~s1Bck;
    rise   = ~s2Bck & s1Bck;
    wsEdge = s1Ws ^ wsPrev;
    isI2s  = (fmt == FMT_I2S);
    stb.sampleRise = rise;
    stb.wsEdge     = wsEdge;
    stb.latchEn    = wsEdge & armed;
    stb.endLeft    = isI2s ? ~wsPrev : wsPrev;
    stb.curLeft    = isI2s ? ~s1Ws : s1Ws;
    stb.sdiBit     = s1Sdi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Bck   <= 1'b0;
      s2Bck   <= 1'b0;
      s1Ws    <= 1'b0;
      wsPrev  <= 1'b0;
      s1Sdi   <= 1'b0;
      armed   <= 1'b0;
      pos     <= '0;
      halfLen <= '0;
    end else begin
      s1Bck  <= bck;
      s2Bck  <= s1Bck;
      s1Ws   <= ws;
      wsPrev <= s1Ws;
      s1Sdi  <= sdi;
      armed  <= armed | wsEdge;
      if (wsEdge) begin
        pos     <= '0;
        halfLen <= {1'b0, pos} + {{POS_W{1'b0}}, fall};
      end else if (fall && pos != '1) begin
        pos <= pos + 1'b1;
      end
    end
  end

  assert_edge_clears_slot_R10: assert property (@(posedge clk) disable iff (!rstN)
    wsEdge |=> pos == '0);

  assert_slot_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!wsEdge && !fall) |=> $stable(pos));

endmodule

// File: rtl/sai_datapath.sv
module sai_datapath
  import sai_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int POS_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtSel_e           fmt,
  input  ctrlStrobe_t       stb,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W:0]    halfLen,
  input  logic [WORD_W-1:0] txLeft,
  input  logic [WORD_W-1:0] txRight,
  output logic [WORD_W-1:0] rxLeft,
  output logic [WORD_W-1:0] rxRight,
  output logic              rxValid,
  output logic              rxIsLeft,
  output logic              sdo
);

  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [WORD_W-1:0] PAD16_MASK = WORD_W'((1 << (WORD_W - 16)) - 1);

  logic              isI2s, rxLsb, txLsb;
  int                nBits, slotRel, lsbRel;
  logic              msbHit, txHit;
  logic [IDX_W-1:0]  msbIdx, txIdx;
  logic [WORD_W-1:0] acc, lsbSh, rxWord, txWord;

  // Format decode and slot arithmetic
  always_comb begin
    isI2s   = (fmt == FMT_I2S);
    rxLsb   = !(fmt inside {FMT_I2S, FMT_MSB});
    txLsb   = fmt inside {FMT_LSB16, FMT_LSB18, FMT_LSB20};
    nBits   = lsbWidth(fmt);
    slotRel = int'(pos) - (isI2s ? 1 : 0);
    msbHit  = (slotRel >= 0) && (slotRel < WORD_W);
    msbIdx  = msbHit ? IDX_W'(WORD_W - 1 - slotRel) : '0;
    rxWord  = rxLsb ? (lsbSh << (WORD_W - nBits)) : acc;
  end

  // Transmit bit selection
  always_comb begin
    txWord = stb.curLeft ? txLeft : txRight;
    txHit  = 1'b0;
    txIdx  = '0;
    lsbRel = 0;
    if (txLsb) begin
      lsbRel = int'(pos) - (int'(halfLen) - nBits);
      if (lsbRel >= 0 && lsbRel < nBits) begin
        txHit = 1'b1;
        txIdx = IDX_W'(WORD_W - 1 - lsbRel);
      end
    end else begin
      txHit = msbHit;
      txIdx = msbIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      lsbSh    <= '0;
      rxLeft   <= '0;
      rxRight  <= '0;
      rxValid  <= 1'b0;
      rxIsLeft <= 1'b0;
      sdo      <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      sdo     <= txHit & txWord[txIdx];
      if (stb.latchEn) begin
        rxValid  <= 1'b1;
        rxIsLeft <= stb.endLeft;
        if (stb.endLeft) rxLeft  <= rxWord;
        else             rxRight <= rxWord;
      end
      if (stb.wsEdge) begin
        acc <= '0;
      end else if (stb.sampleRise) begin
        lsbSh <= {lsbSh[WORD_W-2:0], stb.sdiBit};
        if (msbHit) acc[msbIdx] <= stb.sdiBit;
      end
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_lsb16_pad_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && $past(rxLsb && nBits == 16)) |->
      (((rxIsLeft ? rxLeft : rxRight) & PAD16_MASK) == '0));

  assert_msb_tail_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!txLsb && !isI2s && int'(pos) >= WORD_W) |=> !sdo);

  assert_i2s_slot0_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (isI2s && pos == '0) |=> !sdo);

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
  import sai_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int POS_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        fmt,
  input  logic              bck,
  input  logic              ws,
  input  logic              sdi,
  output logic              sdo,
  input  logic [WORD_W-1:0] txLeft,
  input  logic [WORD_W-1:0] txRight,
  output logic [WORD_W-1:0] rxLeft,
  output logic [WORD_W-1:0] rxRight,
  output logic              rxValid,
  output logic              rxIsLeft
);

  fmtSel_e          fmtSel;
  ctrlStrobe_t      stb;
  logic [POS_W-1:0] pos;
  logic [POS_W:0]   halfLen;

  assign fmtSel = fmtSel_e'(fmt);

  sai_ctrl #(.POS_W(POS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fmt(fmtSel), .bck(bck), .ws(ws), .sdi(sdi),
    .stb(stb), .pos(pos), .halfLen(halfLen)
  );

  sai_datapath #(.WORD_W(WORD_W), .POS_W(POS_W)) u_dp (
    .clk(clk), .rstN(rstN), .fmt(fmtSel), .stb(stb), .pos(pos),
    .halfLen(halfLen), .txLeft(txLeft), .txRight(txRight),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid),
    .rxIsLeft(rxIsLeft), .sdo(sdo)
  );

endmodule

// File: tb/serial_audio_port_tb.sv
module serial_audio_port_tb;

  logic        clk = 1'b0;
  logic        rstN, bck, ws, sdi, sdo, rxValid, rxIsLeft;
  logic [2:0]  fmt;
  logic [19:0] txLeft, txRight, rxLeft, rxRight;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int pulses = 0;
  logic [19:0] gotLeft = '0;
  logic [19:0] gotRight = '0;
  logic lastIsLeft = 1'b0;

  always #2 clk = ~clk;

  serial_audio_port u_dut (
    .clk(clk), .rstN(rstN), .fmt(fmt), .bck(bck), .ws(ws), .sdi(sdi),
    .sdo(sdo), .txLeft(txLeft), .txRight(txRight), .rxLeft(rxLeft),
    .rxRight(rxRight), .rxValid(rxValid), .rxIsLeft(rxIsLeft)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      pulses++;
      lastIsLeft = rxIsLeft;
      if (rxIsLeft) gotLeft = rxLeft;
      else          gotRight = rxRight;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int widthOf(int f);
    if (f == 2 || f == 5) return 16;
    if (f == 3 || f == 6) return 18;
    return 20;
  endfunction

  // style: 0 = I2S, 1 = MSB-justified, 2 = LSB-justified
  function automatic int rxStyle(int f);
    return (f == 0) ? 0 : ((f == 1) ? 1 : 2);
  endfunction

  function automatic int txStyle(int f);
    return (f == 0) ? 0 : ((f >= 2 && f <= 4) ? 2 : 1);
  endfunction

  function automatic bit inWin(int style, int s, int hl, int n);
    if (style == 0) return (s >= 1 && s <= 20);
    if (style == 1) return (s < 20);
    return (s >= hl - n && s < hl);
  endfunction

  function automatic logic slotBit(int style, int s, int hl, int n, logic [19:0] w);
    int k;
    if (!inWin(style, s, hl, n)) return 1'b0;
    if (style == 0)      k = s - 1;
    else if (style == 1) k = s;
    else                 k = s - (hl - n);
    return 1'(w >> (19 - k));
  endfunction

  function automatic int rxExpect(int f, int hl, logic [19:0] w);
    int n;
    int m;
    if (rxStyle(f) == 0)      n = (hl - 1 < 20) ? hl - 1 : 20;
    else if (rxStyle(f) == 1) n = (hl < 20) ? hl : 20;
    else                      n = widthOf(f);
    m = ((1 << n) - 1) << (20 - n);
    return int'(w) & m;
  endfunction

  // One channel half: hl slots, each 16 system clocks long.
  task automatic playHalf(int f, bit left, int hl, logic [19:0] w, bit chk, output int mism);
    logic wsVal;
    logic expBit;
    wsVal = (f == 0) ? !left : left;
    mism = 0;
    for (int s = 0; s < hl; s++) begin
      @(negedge clk) bck = 1'b0;
      @(negedge clk);
      ws  = wsVal;
      sdi = inWin(rxStyle(f), s, hl, widthOf(f)) ? slotBit(rxStyle(f), s, hl, widthOf(f), w) : 1'b1;
      repeat (6) @(negedge clk);
      expBit = slotBit(txStyle(f), s, hl, widthOf(f), left ? txLeft : txRight);
      if (chk && sdo !== expBit) mism++;
      @(negedge clk) bck = 1'b1;
      repeat (7) @(negedge clk);
    end
  endtask

  task automatic runScenario(int f, int hl, logic [19:0] lw, logic [19:0] rw,
                             logic [19:0] tl, logic [19:0] tr,
                             string rxReq, string txReq);
    int m, mL, mR;
    fmt = 3'(f);
    txLeft = tl;
    txRight = tr;
    playHalf(f, 1'b1, hl, 20'h0, 1'b0, m);
    playHalf(f, 1'b0, hl, 20'h0, 1'b0, m);
    pulses = 0;
    playHalf(f, 1'b1, hl, lw, 1'b1, mL);
    playHalf(f, 1'b0, hl, rw, 1'b1, mR);
    playHalf(f, 1'b1, hl, 20'h0, 1'b0, m);
    check(rxReq, $sformatf("fmt%0d hl%0d left word", f, hl), int'(gotLeft), rxExpect(f, hl, lw));
    check(rxReq, $sformatf("fmt%0d hl%0d right word", f, hl), int'(gotRight), rxExpect(f, hl, rw));
    check(txReq, $sformatf("fmt%0d hl%0d sdo left mismatches", f, hl), mL, 0);
    check(txReq, $sformatf("fmt%0d hl%0d sdo right mismatches", f, hl), mR, 0);
    check("R6", $sformatf("fmt%0d pulses/last channel", f), pulses * 2 + int'(lastIsLeft), 6);
  endtask

  task automatic testReset();
    rstN = 1'b0; bck = 1'b0; ws = 1'b0; sdi = 1'b0; fmt = 3'd0;
    txLeft = 20'hFFFFF; txRight = 20'hFFFFF;
    repeat (4) @(negedge clk);
    check("R1", "sdo in reset", int'(sdo), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "rxValid after reset", int'(rxValid), 0);
    check("R1", "rxLeft after reset", int'(rxLeft), 0);
    check("R1", "rxRight after reset", int'(rxRight), 0);
  endtask

  task automatic testFirstEdge();
    ws = 1'b1;
    repeat (10) @(negedge clk);
    check("R6", "no pulse on first transition", pulses, 0);
    ws = 1'b0;
    repeat (10) @(negedge clk);
    check("R6", "pulse on second transition", pulses, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    testReset();
    testFirstEdge();
    runScenario(0, 32, 20'hA5C3E, 20'h5A1C7, 20'h9E3B1, 20'h46D2C, "R2/R3/R10", "R7/R10");
    runScenario(0, 24, 20'h80001, 20'h7FFFE, 20'hC0FFE, 20'h13579, "R3", "R7");
    runScenario(1, 32, 20'h3C9A5, 20'hF0E1D, 20'h2468A, 20'hBDF13, "R2/R4", "R7");
    runScenario(1, 16, 20'hFFFFF, 20'hABCDE, 20'h12345, 20'hFEDCB, "R4", "R7");
    runScenario(2, 32, 20'hDEAD7, 20'h1BEEF, 20'h8F00F, 20'h70FF0, "R5", "R8");
    runScenario(3, 32, 20'h6B5A3, 20'hC3A5F, 20'hA0A0A, 20'h05050, "R5", "R8");
    runScenario(4, 32, 20'h96969, 20'h69696, 20'h33CC3, 20'hCC33C, "R5", "R8");
    runScenario(5, 24, 20'hFFFFF, 20'h81818, 20'h55AA5, 20'hAA55A, "R9/R5", "R9/R7");
    runScenario(6, 24, 20'h4D2E1, 20'hB2D1E, 20'h0F0F0, 20'hF0F0F, "R9/R5", "R9/R7");
    runScenario(7, 32, 20'h7A3C5, 20'h85C3A, 20'hE1E1E, 20'h1E1E1, "R9/R5", "R9/R7");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule